// File: doc/BRIEF.md
# Capacitor Charge-Time Mismatch Meter

This block runs a background sweep that times how long each unit capacitor of a multibit feedback DAC takes to charge. It handles one capacitor per phase. While a capacitor is under test, a spare capacitor stands in for it in the DAC. The engine points the analog switches at that capacitor and raises a discharge strobe for a fixed number of clocks. When the strobe falls, it counts system clocks for as long as an external comparator stays high. The comparator drops once the capacitor voltage passes the reference. At the end of the phase the count is stored, along with two flags: overflow and invalid (timed out).

Once every capacitor has been timed, a sequential restoring divider turns each count into a signed fixed-point mismatch estimate. Each estimate is the element's count divided by the count of the last capacitor, minus one. Using a ratio cancels any offset in the comparator and any gain error in the current source that are common to all elements. A done flag goes high when every estimate has been written and stays high until the next sweep is requested.

Top module: `cap_mismatch_meter`

## Requirements
- R1: After reset, `done_o`, `meas_act_o` and `dis_o` are low and every error field of `err_o` is zero.
- R2: A `start_i` pulse seen while idle or finished begins a sweep of NUM = 2^NBITS phases. `sel_o` steps 0, 1, …, NUM-1 in order. `meas_act_o` is high for exactly NUM·PHASE_LEN clocks, which with the default PHASE_LEN = 2^11 is 2^(11+NBITS).
- R3: Each phase opens with exactly DIS_LEN clocks of `dis_o` high, so `dis_o` is high for NUM·DIS_LEN clocks per sweep.
- R4: An element's count is the number of clocks after `dis_o` falls during which `cmp_i` is high, up to its first low sample. Later highs in the same phase are not counted. The count is captured on the last clock of the phase.
- R5: The count saturates at 2^CNT_W-1 instead of wrapping. `ovf_o[j]` is set when element j's stored count equals that value.
- R6: If `cmp_i` is still high on the last clock of a phase, the phase ends anyway and `inv_o[j]` is set. Otherwise it is cleared.
- R7: Field j of `err_o` (bits j·ERR_W upward, ERR_W = CNT_W+FRAC_W+1) is the two's-complement value floor(a_j·2^FRAC_W / a_ref) - 2^FRAC_W. Here a_ref is the count of element NUM-1, whose own estimate is therefore 0. For example, counts 1002 over 1000 with FRAC_W = 12 give 8.
- R8: If the reference count is zero, every error field is written as zero.
- R9: `done_o` rises once all NUM estimates are written and holds until the next accepted start. A `start_i` pulse during a sweep or a division is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the timing reference for charge counts |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new measurement sweep |
| cmp_i | input | 1 | Comparator output, high while capacitor voltage is below reference |
| sel_o | output | IDX_W | Index of the capacitor under test |
| meas_act_o | output | 1 | High while a capacitor is replaced by the spare |
| dis_o | output | 1 | Discharge strobe for the capacitor under test |
| err_o | output | NUM·ERR_W | Packed signed error estimates, element j in field j |
| ovf_o | output | NUM | Per-element saturated-count flag |
| inv_o | output | NUM | Per-element timeout (comparator never fell) flag |
| done_o | output | 1 | All estimates written |

## Verification
The bench targets several corners of the counting and division path:
- A comparator that never falls: a design without the timeout would report a wrong count or a clear invalid flag.
- A charge time past the counter's range: a wrapping counter would give a tiny count and a large negative error.
- A reference count of zero: the divider would return all-ones garbage instead of zeros.
- A second start mid-sweep: a design that restarts would stretch the measure window.

Exact ratios such as 1002/1000, and random counts near full scale, catch any off-by-one in the count window or in the quotient bits.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_DIV_GO,
    ST_DIV_WAIT,
    ST_DONE
  } cmm_state_e;
endpackage

// File: rtl/cmm_phase_seq.sv
module cmm_phase_seq #(
  parameter int NUM       = 4,
  parameter int PHASE_LEN = 2048,
  parameter int DIS_LEN   = 4,
  localparam int IDX_W    = $clog2(NUM),
  localparam int PC_W     = $clog2(PHASE_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             run_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             dis_o,
  output logic             phase_end_o,
  output logic             last_phase_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sel_o <= '0;
    end else if (launch_i) begin
      pc_q  <= '0;
      sel_o <= '0;
    end else if (run_i) begin
      if (phase_end_o) begin
        pc_q  <= '0;
        sel_o <= sel_o + 1'b1;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign dis_o        = run_i && (pc_q < PC_W'(DIS_LEN));
  assign phase_end_o  = run_i && (pc_q == PC_W'(PHASE_LEN - 1));
  assign last_phase_o = (sel_o == IDX_W'(NUM - 1));

  // R2: phases advance one element at a time
  a_r2_sel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end_o && !last_phase_o && !launch_i) |=> (sel_o == $past(sel_o) + 1'b1));
  // R3: a phase begins with the discharge strobe
  a_r3_dis_at_phase_start: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_end_o && !last_phase_o && !launch_i) |=> dis_o);
endmodule

// File: rtl/cmm_charge_cnt.sv
module cmm_charge_cnt #(
  parameter int CNT_W = 11,
  localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             cmp_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             stop_nxt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             stop_q;

  always_comb begin
    cnt_nxt_o  = cnt_q;
    stop_nxt_o = stop_q;
    if (clr_i) begin
      cnt_nxt_o  = '0;
      stop_nxt_o = 1'b0;
    end else if (en_i && !stop_q) begin
      if (cmp_i) cnt_nxt_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
      else       stop_nxt_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt_o;
      stop_q <= stop_nxt_o;
    end
  end

  // R4: once the comparator has fallen the count freezes
  a_r4_frozen_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !clr_i) |=> $stable(cnt_q));
  // R5: saturated count never wraps
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/cmm_restoring_div.sv
module cmm_restoring_div #(
  parameter int DW = 23,
  parameter int VW = 11,
  localparam int SW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [VW-1:0] divisor_i,
  output logic [DW-1:0] quo_o,
  output logic          done_o
);
  logic [VW-1:0] rem_q;
  logic [SW-1:0] step_q;
  logic          busy_q;
  logic [VW:0]   trial;
  logic          fits;

  assign trial = {rem_q, quo_o[DW-1]};
  assign fits  = (trial >= {1'b0, divisor_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_o  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_o  <= dividend_i;
        step_q <= SW'(DW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= fits ? VW'(trial - {1'b0, divisor_i}) : VW'(trial);
        quo_o  <= {quo_o[DW-2:0], fits};
        step_q <= step_q - 1'b1;
        if (step_q == SW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  logic [DW+VW-1:0] prod_w;
  assign prod_w = quo_o * divisor_i;
  // R7: quotient is the floor of the exact ratio
  a_r7_floor_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && divisor_i != '0) |->
      ((prod_w <= (DW+VW)'(dividend_i)) &&
       ((DW+VW)'(dividend_i) - prod_w < (DW+VW)'(divisor_i))));
endmodule

// File: rtl/cap_mismatch_meter.sv
module cap_mismatch_meter
  import cmm_pkg::*;
#(
  parameter int NBITS     = 2,
  parameter int CNT_W     = 11,
  parameter int FRAC_W    = 12,
  parameter int PHASE_LEN = 2048,
  parameter int DIS_LEN   = 4,
  localparam int NUM      = 1 << NBITS,
  localparam int IDX_W    = $clog2(NUM),
  localparam int DW       = CNT_W + FRAC_W,
  localparam int ERR_W    = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 cmp_i,
  output logic [IDX_W-1:0]     sel_o,
  output logic                 meas_act_o,
  output logic                 dis_o,
  output logic [NUM*ERR_W-1:0] err_o,
  output logic [NUM-1:0]       ovf_o,
  output logic [NUM-1:0]       inv_o,
  output logic                 done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [ERR_W-1:0] fx_err(input logic [DW-1:0] q);
    return {1'b0, q} - (ERR_W'(1) << FRAC_W);
  endfunction

  cmm_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_mem [NUM];
  logic [ERR_W-1:0] err_q   [NUM];
  logic             launch_w, phase_end_w, last_phase_w, stop_nxt_w;
  logic [CNT_W-1:0] cnt_nxt_w;
  logic             div_go_w, div_done_w;
  logic [DW-1:0]    div_quo_w;
  logic             ref_zero_w;

  assign launch_w   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign meas_act_o = (state_q == ST_MEAS);
  assign done_o     = (state_q == ST_DONE);
  assign ref_zero_w = (cnt_mem[NUM-1] == '0);
  assign div_go_w   = (state_q == ST_DIV_GO) && !ref_zero_w;

  cmm_phase_seq #(.NUM(NUM), .PHASE_LEN(PHASE_LEN), .DIS_LEN(DIS_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_w), .run_i(meas_act_o),
    .sel_o(sel_o), .dis_o(dis_o), .phase_end_o(phase_end_w), .last_phase_o(last_phase_w));

  cmm_charge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(dis_o), .en_i(meas_act_o), .cmp_i(cmp_i),
    .cnt_nxt_o(cnt_nxt_w), .stop_nxt_o(stop_nxt_w));

  cmm_restoring_div #(.DW(DW), .VW(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(div_go_w),
    .dividend_i({cnt_mem[idx_q], FRAC_W'(0)}), .divisor_i(cnt_mem[NUM-1]),
    .quo_o(div_quo_w), .done_o(div_done_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ovf_o   <= '0;
      inv_o   <= '0;
      for (int i = 0; i < NUM; i++) begin
        cnt_mem[i] <= '0;
        err_q[i]   <= '0;
      end
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (launch_w) state_q <= ST_MEAS;
        ST_MEAS: if (phase_end_w) begin
          cnt_mem[sel_o] <= cnt_nxt_w;
          ovf_o[sel_o]   <= (cnt_nxt_w == CNT_MAX);
          inv_o[sel_o]   <= !stop_nxt_w;
          if (last_phase_w) begin
            state_q <= ST_DIV_GO;
            idx_q   <= '0;
          end
        end
        ST_DIV_GO: begin
          if (ref_zero_w) begin
            err_q[idx_q] <= '0;
            if (idx_q == IDX_W'(NUM - 1)) state_q <= ST_DONE;
            else idx_q <= idx_q + 1'b1;
          end else begin
            state_q <= ST_DIV_WAIT;
          end
        end
        ST_DIV_WAIT: if (div_done_w) begin
          err_q[idx_q] <= fx_err(div_quo_w);
          if (idx_q == IDX_W'(NUM - 1)) state_q <= ST_DONE;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_DIV_GO;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_pack
    assign err_o[g*ERR_W +: ERR_W] = err_q[g];
  end

  // R9: done holds until a new start is accepted
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // R9: a start while busy does not restart the sweep
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_act_o && !phase_end_w) |=> meas_act_o);
  // R3: discharge only while measuring
  a_r3_dis_in_meas: assert property (@(posedge clk) disable iff (!rst_n)
    dis_o |-> meas_act_o);
  // R8: zero reference never launches a division
  a_r8_no_div_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    div_go_w |-> (cnt_mem[NUM-1] != '0));
endmodule

// File: tb/cap_mismatch_meter_bench.sv
module cap_mismatch_meter_bench;
  localparam int NBITS = 2, CNT_W = 10, FRAC_W = 12, PHASE_LEN = 2048, DIS_LEN = 4;
  localparam int NUM = 1 << NBITS, IDX_W = $clog2(NUM);
  localparam int ERR_W = CNT_W + FRAC_W + 1;
  localparam int WIN = PHASE_LEN - DIS_LEN;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, start = 0, cmp = 1;
  logic [IDX_W-1:0] sel;
  logic meas_act, dis, done;
  logic [NUM*ERR_W-1:0] err;
  logic [NUM-1:0] ovf, inv;

  int n_tests = 0, n_fail = 0;
  int kk [NUM];
  int ccyc = 0, meas_cyc = 0, dis_cyc = 0, exp_sel = 0;
  bit sel_bad = 0, prev_dis = 0;

  always #10 clk = ~clk;

  cap_mismatch_meter #(.NBITS(NBITS), .CNT_W(CNT_W), .FRAC_W(FRAC_W),
    .PHASE_LEN(PHASE_LEN), .DIS_LEN(DIS_LEN)) u_cap_mismatch_meter (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp), .sel_o(sel),
    .meas_act_o(meas_act), .dis_o(dis), .err_o(err), .ovf_o(ovf), .inv_o(inv),
    .done_o(done));

  // comparator model and monitors, away from the active edge
  always @(negedge clk) begin
    if (dis) begin ccyc <= 0; cmp <= 1'b1; end
    else if (meas_act) begin cmp <= (ccyc < kk[sel]); ccyc <= ccyc + 1; end
    else cmp <= 1'b1;
    if (meas_act) meas_cyc <= meas_cyc + 1;
    if (dis) dis_cyc <= dis_cyc + 1;
    if (dis && !prev_dis) begin
      if (int'(sel) != exp_sel) sel_bad <= 1;
      exp_sel <= exp_sel + 1;
    end
    prev_dis <= dis;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_of(input int k);
    int e = (k < WIN) ? k : WIN;
    return (e > MAXC) ? MAXC : e;
  endfunction

  function automatic logic [ERR_W-1:0] err_of(input int aj, input int ar);
    longint q;
    if (ar == 0) return '0;
    q = (longint'(aj) << FRAC_W) / ar;
    return ERR_W'(q - (longint'(1) << FRAC_W));
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic sweep(input int k0, input int k1, input int k2, input int k3,
                       input bit busy_start);
    int guard = 0;
    kk[0] = k0; kk[1] = k1; kk[2] = k2; kk[3] = k3;
    @(negedge clk);
    meas_cyc = 0; dis_cyc = 0; exp_sel = 0; sel_bad = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    check("R9 done low while busy", done, 0);
    if (busy_start) begin
      repeat (3000) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    while (!done && guard < 30000) begin @(negedge clk); guard++; end
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog actual=0 expected=1");
      finish_run();
    end
    check("R2 measure window length", meas_cyc, NUM * PHASE_LEN);
    check("R2 select order", sel_bad, 0);
    check("R3 discharge clocks", dis_cyc, NUM * DIS_LEN);
    for (int j = 0; j < NUM; j++) begin
      int a = cnt_of(kk[j]);
      check($sformatf("R4 R7 R8 err[%0d]", j), err[j*ERR_W +: ERR_W],
            err_of(a, cnt_of(kk[NUM-1])));
      check($sformatf("R5 ovf[%0d]", j), ovf[j], (a == MAXC) ? 1 : 0);
      check($sformatf("R6 inv[%0d]", j), inv[j], (kk[j] >= WIN) ? 1 : 0);
    end
    repeat (4) @(negedge clk);
    check("R9 done holds", done, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4321));
    for (int j = 0; j < NUM; j++) kk[j] = 0;
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 meas_act", meas_act, 0);
    check("R1 dis", dis, 0);
    check("R1 err zero", (err == '0) ? 1 : 0, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // exact ratio: 1002/1000 gives 8 at FRAC_W 12
    sweep(1002, 998, 1010, 1000, 0);
    check("R7 example value", err[0 +: ERR_W], 8);
    // saturation, timeout, tiny count
    sweep(1500, 3000, 5, 700, 0);
    // zero reference count
    sweep(800, 900, 1000, 0, 0);
    // ignored start during sweep
    sweep(950, 1023, 1, 1020, 1);
    for (int r = 0; r < 3; r++)
      sweep(600 + int'($urandom_range(0, 423)), 600 + int'($urandom_range(0, 423)),
            600 + int'($urandom_range(0, 423)), 600 + int'($urandom_range(0, 423)), 0);
    finish_run();
  end
endmodule